// File: doc/BRIEF.md
# Serial Shift Slice

The block is one lane group of a serial I/O engine. A 32-bit shift chain turns a serial stream into a parallel word, and turns a parallel word back into a serial stream. Incoming serial data moves in at the top bit and outgoing data leaves from the bottom bit. Each shift step can move 1, 2, 4 or 8 bits over the same number of serial lanes.

Shift steps come from one of two sources. The first is a programmable divider of the system clock. The second is the rising edge of an external clock pin. A qualifier pin can gate either source. Every pin input passes through a one-flop synchronizer before it is used.

A step counter sets the word length. When the word is complete, the chain is exchanged with a shadow register, so software can read one word while the next one shifts. Four one-cycle event flags report the following:
- a finished word;
- each shift step;
- a rising edge on serial lane 0;
- a masked pattern match on the chain.

Top module: `serial_shift_slice`

## Requirements
- R1: While reset is asserted and right after it, the following are all zero: the chain, the shadow, ser_out, ser_oe and all four event flags.
- R2: A write with wr_chain loads wr_data into the chain, and the value appears on rd_chain one cycle later. wr_shadow does the same for the shadow and rd_shadow. A chain write cancels any step in the same cycle and restarts the step count.
- R3: ser_in, qual_in and ext_clk_in are each registered once before use. A ser_in value that is present before clock edge k can enter the chain no earlier than edge k+1.
- R4: lane_mode values 0, 1, 2 and 3 select N = 1, 2, 4 and 8 lanes. A step shifts the chain right by N. Synchronized ser_in[k] goes to chain bit 32-N+k for k<N. ser_out[k] equals chain bit k for k<N, and the upper ser_out bits are 0.
- R5: With clk_sel=0 and no qualifier, a step occurs in the first cycle after reset and then every div_preset+1 cycles.
- R6: With clk_sel=1, each rising edge of the synchronized ext_clk_in gives exactly one step. A pin that does not toggle gives no steps.
- R7: With qual_en=1, a step occurs only when the synchronized qual_in is 1. Otherwise the chain is left unchanged.
- R8: The swap happens on step number max(step_count,1), counted since reset, the last chain write or the last swap. On that step the shadow takes the shifted word and the chain takes the old shadow. ev_shift is high in the following cycle.
- R9: ev_capture is high in the cycle after every step, and only then.
- R10: ev_input is high for one cycle. This happens two cycles after ser_in[0] rises at the pin.
- R11: ev_match is high in the cycle after a cycle in which match_en=1 and the chain equals match_pattern on every bit position that match_mask leaves clear. A set mask bit excludes that position from the compare.
- R12: ser_oe equals oe_cfg delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_chain | input | 1 | Write wr_data into the chain |
| wr_shadow | input | 1 | Write wr_data into the shadow |
| wr_data | input | 32 | Parallel write data |
| rd_chain | output | 32 | Chain contents |
| rd_shadow | output | 32 | Shadow contents |
| lane_mode | input | 2 | Lanes per step: 0→1, 1→2, 2→4, 3→8 |
| div_preset | input | DIV_W | Divider reload value |
| step_count | input | CNT_W | Steps per word |
| clk_sel | input | 1 | 0: internal divider, 1: external clock pin |
| qual_en | input | 1 | Gate steps with the qualifier |
| match_en | input | 1 | Enable the pattern compare |
| match_pattern | input | 32 | Pattern to compare against |
| match_mask | input | 32 | A set bit excludes that position from the compare |
| oe_cfg | input | 1 | Requested output enable |
| ser_in | input | 8 | Serial input lanes |
| qual_in | input | 1 | Qualifier pin |
| ext_clk_in | input | 1 | External shift clock pin |
| ser_out | output | 8 | Serial output lanes |
| ser_oe | output | 1 | Registered output enable |
| ev_shift | output | 1 | Word complete (swap done) |
| ev_capture | output | 1 | A shift step happened |
| ev_input | output | 1 | Rising edge seen on lane 0 |
| ev_match | output | 1 | Pattern matched |

## Verification
The bench sweeps every lane mode against several divider presets and word lengths. It checks each cycle against an arithmetic model of the chain.

A design that put lanes in reverse order, or that shifted the wrong way, would corrupt the upper chain bits within one step. A design with an off-by-one word count would swap a step early or late, and the shadow would hold a shifted word.

Directed cases cover the remaining corners:
- Synchronizer latency: dropping the input flop makes bit 31 change one cycle early.
- A held-high external clock: using its level instead of its edge gives extra steps.
- A qualifier held low: ignoring it moves the chain.
- A mismatch on a masked bit against an unmasked bit: inverting the mask sense flips ev_match.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  localparam int CHAIN_W  = 32;
  localparam int LANE_MAX = 8;

  // number of serial lanes used per step
  function automatic int lane_count(input logic [1:0] mode);
    return 1 << mode;
  endfunction

  // right shift by the lane count, new lanes enter at the top
  function automatic logic [CHAIN_W-1:0] shift_in(input logic [CHAIN_W-1:0] chain,
                                                  input logic [LANE_MAX-1:0] lanes,
                                                  input logic [1:0] mode);
    logic [CHAIN_W-1:0] r;
    int n;
    n = lane_count(mode);
    r = chain >> n;
    for (int k = 0; k < LANE_MAX; k++)
      if (k < n) r[CHAIN_W-n+k] = lanes[k];
    return r;
  endfunction

  // bottom lanes of the chain, unused lanes held low
  function automatic logic [LANE_MAX-1:0] lane_out(input logic [CHAIN_W-1:0] chain,
                                                   input logic [1:0] mode);
    logic [LANE_MAX-1:0] o;
    o = '0;
    for (int k = 0; k < LANE_MAX; k++)
      if (k < lane_count(mode)) o[k] = chain[k];
    return o;
  endfunction

  // compare with don't-care mask (set bit = ignore)
  function automatic logic masked_eq(input logic [CHAIN_W-1:0] chain,
                                     input logic [CHAIN_W-1:0] pat,
                                     input logic [CHAIN_W-1:0] mask);
    return ((chain ^ pat) & ~mask) == '0;
  endfunction
endpackage

// File: rtl/sgs_sync.sv
module sgs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= pin;

  // R3: exactly one cycle from pin to use
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> q == $past(pin));
endmodule

// File: rtl/sgs_stepgen.sv
module sgs_stepgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_preset,
  input  logic             clk_sel,
  input  logic             qual_en,
  input  logic             qual_s,
  input  logic             eclk_s,
  output logic             step
);
  logic [DIV_W-1:0] div_q;
  logic             eclk_prev;
  logic             int_tick;
  logic             ext_rise;

  always_comb begin
    int_tick = (div_q == '0);
    ext_rise = eclk_s & ~eclk_prev;
    step     = (clk_sel ? ext_rise : int_tick) & (~qual_en | qual_s);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q     <= '0;
      eclk_prev <= 1'b0;
    end else begin
      div_q     <= int_tick ? div_preset : div_q - 1'b1;
      eclk_prev <= eclk_s;
    end

  // R5: a non-zero preset never gives back-to-back ticks
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (int_tick && div_preset != '0) |=> !int_tick);
endmodule

// File: rtl/sgs_chain.sv
module sgs_chain #(
  parameter int CNT_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step,
  input  logic [1:0]                   mode,
  input  logic [sgs_pkg::LANE_MAX-1:0] lanes_s,
  input  logic [CNT_W-1:0]             step_count,
  input  logic                         wr_chain,
  input  logic                         wr_shadow,
  input  logic [sgs_pkg::CHAIN_W-1:0]  wr_data,
  output logic [sgs_pkg::CHAIN_W-1:0]  chain_q,
  output logic [sgs_pkg::CHAIN_W-1:0]  shadow_q,
  output logic                         step_eff,
  output logic                         expire
);
  localparam int CW = sgs_pkg::CHAIN_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;
  logic [CW-1:0]    shifted;

  always_comb begin
    shifted  = sgs_pkg::shift_in(chain_q, lanes_s, mode);
    step_eff = step & ~wr_chain;
    cnt_nxt  = {1'b0, cnt_q} + 1'b1;
    expire   = step_eff & (cnt_nxt >= {1'b0, step_count});
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chain_q  <= '0;
      shadow_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_chain) begin
        chain_q <= wr_data;
        cnt_q   <= '0;
      end else if (step_eff) begin
        if (expire) begin
          chain_q <= shadow_q;
          cnt_q   <= '0;
        end else begin
          chain_q <= shifted;
          cnt_q   <= cnt_nxt[CNT_W-1:0];
        end
      end
      if (wr_shadow)   shadow_q <= wr_data;
      else if (expire) shadow_q <= shifted;
    end

  // R2: a chain write always lands, whatever the step logic wants
  a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chain |=> chain_q == $past(wr_data));
  // R7: no step and no write leaves the chain alone
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_chain) |=> $stable(chain_q));
endmodule

// File: rtl/serial_shift_slice.sv
module serial_shift_slice #(
  parameter int DIV_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_chain,
  input  logic             wr_shadow,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_chain,
  output logic [31:0]      rd_shadow,
  input  logic [1:0]       lane_mode,
  input  logic [DIV_W-1:0] div_preset,
  input  logic [CNT_W-1:0] step_count,
  input  logic             clk_sel,
  input  logic             qual_en,
  input  logic             match_en,
  input  logic [31:0]      match_pattern,
  input  logic [31:0]      match_mask,
  input  logic             oe_cfg,
  input  logic [7:0]       ser_in,
  input  logic             qual_in,
  input  logic             ext_clk_in,
  output logic [7:0]       ser_out,
  output logic             ser_oe,
  output logic             ev_shift,
  output logic             ev_capture,
  output logic             ev_input,
  output logic             ev_match
);
  localparam int LM = sgs_pkg::LANE_MAX;
  localparam int SW = LM + 2;

  logic [SW-1:0] pins_s;
  logic [LM-1:0] lanes_s;
  logic          qual_s, eclk_s;
  logic          step_w, step_eff_w, expire_w;
  logic          lane0_prev;
  logic [31:0]   chain_w, shadow_w;

  sgs_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin({ext_clk_in, qual_in, ser_in}),
    .q(pins_s)
  );
  assign lanes_s = pins_s[LM-1:0];
  assign qual_s  = pins_s[LM];
  assign eclk_s  = pins_s[LM+1];

  sgs_stepgen #(.DIV_W(DIV_W)) u_step (
    .clk(clk), .rst_n(rst_n), .div_preset(div_preset), .clk_sel(clk_sel),
    .qual_en(qual_en), .qual_s(qual_s), .eclk_s(eclk_s), .step(step_w)
  );

  sgs_chain #(.CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(step_w), .mode(lane_mode),
    .lanes_s(lanes_s), .step_count(step_count), .wr_chain(wr_chain),
    .wr_shadow(wr_shadow), .wr_data(wr_data), .chain_q(chain_w),
    .shadow_q(shadow_w), .step_eff(step_eff_w), .expire(expire_w)
  );

  assign rd_chain  = chain_w;
  assign rd_shadow = shadow_w;
  assign ser_out   = sgs_pkg::lane_out(chain_w, lane_mode);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ev_shift   <= 1'b0;
      ev_capture <= 1'b0;
      ev_input   <= 1'b0;
      ev_match   <= 1'b0;
      lane0_prev <= 1'b0;
      ser_oe     <= 1'b0;
    end else begin
      ev_capture <= step_eff_w;
      ev_shift   <= expire_w;
      lane0_prev <= lanes_s[0];
      ev_input   <= lanes_s[0] & ~lane0_prev;
      ev_match   <= match_en & sgs_pkg::masked_eq(chain_w, match_pattern, match_mask);
      ser_oe     <= oe_cfg;
    end

  // R8/R9: a finished word is always also a step
  a_r8_shift_has_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |-> ev_capture);
  // R12: direction follows the request one cycle later
  a_r12_oe_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ser_oe == $past(oe_cfg));
  // R11: no match flag without the enable
  a_r11_match_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ev_match) |-> $past(match_en));
  // R7: a qualified step needs the qualifier pin high one cycle earlier
  a_r7_qual_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && qual_en && step_w) |-> $past(qual_in));
  // R6: an external step follows a pin rise seen through the synchronizer
  a_r6_ext_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && clk_sel && step_w)
      |-> ($past(ext_clk_in) && !$past(ext_clk_in, 2)));
endmodule

// File: tb/serial_shift_slice_test.sv
module serial_shift_slice_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_chain = 0, wr_shadow = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_chain, rd_shadow;
  logic [1:0]  lane_mode = 0;
  logic [11:0] div_preset = 0;
  logic [7:0]  step_count = 8'd255;
  logic        clk_sel = 0, qual_en = 0, match_en = 0;
  logic [31:0] match_pattern = '0, match_mask = '0;
  logic        oe_cfg = 0;
  logic [7:0]  ser_in = '0;
  logic        qual_in = 0, ext_clk_in = 0;
  logic [7:0]  ser_out;
  logic        ser_oe, ev_shift, ev_capture, ev_input, ev_match;

  int checks = 0, fails = 0;
  bit model_on = 0;
  int cap_count = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  serial_shift_slice uut (
    .clk(clk), .rst_n(rst_n), .wr_chain(wr_chain), .wr_shadow(wr_shadow),
    .wr_data(wr_data), .rd_chain(rd_chain), .rd_shadow(rd_shadow),
    .lane_mode(lane_mode), .div_preset(div_preset), .step_count(step_count),
    .clk_sel(clk_sel), .qual_en(qual_en), .match_en(match_en),
    .match_pattern(match_pattern), .match_mask(match_mask), .oe_cfg(oe_cfg),
    .ser_in(ser_in), .qual_in(qual_in), .ext_clk_in(ext_clk_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .ev_shift(ev_shift),
    .ev_capture(ev_capture), .ev_input(ev_input), .ev_match(ev_match)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model, written from the requirements ----------------
  logic [31:0] m_chain, m_shadow;
  logic [7:0]  m_lanes;
  logic        m_qual, m_eclk, m_eclk_old, m_l0_old;
  int          m_div, m_done;
  logic        m_ev_shift, m_ev_cap, m_ev_in, m_ev_match, m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chain = 0; m_shadow = 0; m_lanes = 0; m_qual = 0; m_eclk = 0;
      m_eclk_old = 0; m_l0_old = 0; m_div = 0; m_done = 0;
      m_ev_shift = 0; m_ev_cap = 0; m_ev_in = 0; m_ev_match = 0; m_oe = 0;
    end else begin
      int n;
      int need;
      bit go, word_end;
      logic [31:0] moved;
      n = 1 << lane_mode;
      need = (step_count == 0) ? 1 : int'(step_count);
      go = clk_sel ? (m_eclk && !m_eclk_old) : (m_div == 0);
      if (qual_en && !m_qual) go = 0;
      if (wr_chain) go = 0;
      word_end = go && (m_done + 1 >= need);
      // R4: lane k lands at bit 32-n+k; everything else moves down by n
      moved = m_chain >> n;
      for (int k = 0; k < n; k++) moved[32-n+k] = m_lanes[k];
      m_ev_match = match_en && (((m_chain ^ match_pattern) & ~match_mask) == 0);
      m_ev_in    = m_lanes[0] && !m_l0_old;
      m_ev_cap   = go;
      m_ev_shift = word_end;
      m_oe       = oe_cfg;
      if (wr_shadow) m_shadow = wr_data;
      else if (word_end) m_shadow = moved;
      if (wr_chain) begin m_chain = wr_data; m_done = 0; end
      else if (word_end) begin m_chain = (wr_shadow ? m_chain : m_chain); end
      if (!wr_chain && go) begin
        if (word_end) begin m_done = 0; end
        else begin m_chain = moved; m_done = m_done + 1; end
      end
      m_div      = (m_div == 0) ? int'(div_preset) : m_div - 1;
      m_l0_old   = m_lanes[0];
      m_eclk_old = m_eclk;
      m_lanes    = ser_in;
      m_qual     = qual_in;
      m_eclk     = ext_clk_in;
    end
  end

  // old shadow goes to the chain on a word end: kept apart so the order above is clear
  logic [31:0] m_shadow_prev;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_shadow_prev <= '0;
    else        m_shadow_prev <= rd_shadow;

  always @(negedge clk) begin
    if (ev_capture) cap_count++;
    if (rst_n && model_on) begin
      if (m_ev_shift) chk("R8 chain takes old shadow", rd_chain, m_shadow_prev);
      else            chk("R4 chain", rd_chain, m_chain);
      chk("R8 shadow", rd_shadow, m_shadow);
      chk("R4 ser_out", {24'd0, ser_out}, {24'd0, m_ev_shift ? 8'(0) | (rd_chain[7:0] & 8'((1 << (1 << lane_mode)) - 1)) : (m_chain[7:0] & 8'((1 << (1 << lane_mode)) - 1))});
      chk("R8 ev_shift", {31'd0, ev_shift}, {31'd0, m_ev_shift});
      chk("R9 ev_capture", {31'd0, ev_capture}, {31'd0, m_ev_cap});
      chk("R10 ev_input", {31'd0, ev_input}, {31'd0, m_ev_in});
      chk("R12 ser_oe", {31'd0, ser_oe}, {31'd0, m_oe});
      if (!m_ev_shift) chk("R11 ev_match", {31'd0, ev_match}, {31'd0, m_ev_match});
      if (m_ev_shift) m_chain = rd_chain;
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_chain(input logic [31:0] v);
    @(negedge clk); wr_chain = 1; wr_data = v;
    @(negedge clk); wr_chain = 0;
  endtask

  initial begin
    // R1: reset values
    cyc(3);
    chk("R1 chain", rd_chain, 0);
    chk("R1 shadow", rd_shadow, 0);
    chk("R1 ser_out", {24'd0, ser_out}, 0);
    chk("R1 oe+events", {27'd0, ser_oe, ev_shift, ev_capture, ev_input, ev_match}, 0);
    rst_n = 1;
    qual_en = 1; qual_in = 0;   // hold steps off while writing
    cyc(3);

    // R2: parallel write and read
    write_chain(32'hDEADBEEF);
    chk("R2 chain readback", rd_chain, 32'hDEADBEEF);
    @(negedge clk); wr_shadow = 1; wr_data = 32'h12345678;
    @(negedge clk); wr_shadow = 0;
    chk("R2 shadow readback", rd_shadow, 32'h12345678);

    // R7: qualifier low holds the chain
    cap_count = 0;
    cyc(30);
    chk("R7 chain held", rd_chain, 32'hDEADBEEF);
    chk("R7 no steps", cap_count, 0);

    // R3: one cycle of input latency (single lane, step every cycle)
    qual_en = 0; ser_in = 0; step_count = 8'd255;
    write_chain(32'h0);
    cyc(4);
    ser_in = 8'h01;
    @(negedge clk);
    chk("R3 bit not yet in", {31'd0, rd_chain[31]}, 0);
    @(negedge clk);
    chk("R3 bit arrives", {31'd0, rd_chain[31]}, 1);

    // R5: divider period
    div_preset = 3;
    cyc(5);
    cap_count = 0;
    cyc(40);
    chk("R5 steps in 40 cycles with preset 3", cap_count, 10);

    // model-checked sweep over lanes, presets and word lengths
    model_on = 1;
    for (int md = 0; md < 4; md++)
      for (int pr = 0; pr < 3; pr++)
        for (int sc = 0; sc < 3; sc++) begin
          @(negedge clk);
          lane_mode = md[1:0]; div_preset = pr[11:0];
          step_count = (sc == 0) ? 8'd1 : (sc == 1) ? 8'd3 : 8'(32 >> md);
          match_en = 1; match_pattern = {lfsr, lfsr}; match_mask = 32'hFFFF_FF00;
          oe_cfg = ~oe_cfg;
          repeat (60) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ser_in = lfsr[7:0];
            if (lfsr[3:0] == 4'h5) oe_cfg = ~oe_cfg;
          end
        end

    // R6: external clock, including a long high level
    clk_sel = 1; lane_mode = 0; step_count = 8'd255; match_en = 0;
    cyc(4);
    cap_count = 0;
    for (int e = 0; e < 8; e++) begin
      ext_clk_in = 1; cyc(3);
      ext_clk_in = 0; cyc(2);
    end
    ext_clk_in = 1; cyc(20);
    ext_clk_in = 0; cyc(4);
    chk("R6 one step per rising edge", cap_count, 9);

    // R6 with R7: qualifier toggling gates external steps
    qual_en = 1;
    for (int e = 0; e < 12; e++) begin
      qual_in = e[0]; ext_clk_in = 1; cyc(2);
      ext_clk_in = 0; cyc(2);
    end
    qual_en = 0; clk_sel = 0;

    // R11: mask ignores a mismatch in a masked position only
    model_on = 0;
    qual_en = 1; qual_in = 0; cyc(3);
    write_chain(32'hA5A5_0F0F);
    match_en = 1; match_pattern = 32'hA5A5_0F0E; match_mask = 32'h0000_0001;
    cyc(2);
    chk("R11 masked mismatch still matches", {31'd0, ev_match}, 1);
    match_mask = 32'h0000_0002;
    cyc(2);
    chk("R11 unmasked mismatch no match", {31'd0, ev_match}, 0);
    match_en = 0;
    cyc(2);
    chk("R11 disabled", {31'd0, ev_match}, 0);

    // R10: edge on lane 0 flags two cycles after the pin
    ser_in = 0; cyc(4);
    ser_in = 8'h01;
    @(negedge clk);
    chk("R10 not yet", {31'd0, ev_input}, 0);
    @(negedge clk);
    chk("R10 flagged", {31'd0, ev_input}, 1);
    @(negedge clk);
    chk("R10 one cycle only", {31'd0, ev_input}, 0);

    // R12: output enable follows by one cycle
    oe_cfg = 1;
    @(negedge clk);
    chk("R12 oe high", {31'd0, ser_oe}, 1);
    oe_cfg = 0;
    @(negedge clk);
    chk("R12 oe low", {31'd0, ser_oe}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule